// File: doc/BRIEF.md
# Double-Buffered Frame Store Controller

This block drives two external SRAM banks as a double buffer for a display scanner. Pixel words arrive on a write port with a valid strobe. The block stores them in the bank that currently has the write role, at addresses it counts up from zero in the order the words arrive. At the same time the scan sequencer reads the other bank. It gives its own address with each read request, so it can read the frame in any order the scan needs. The block returns the word on a registered read-data port.

Each bank has its own active-low chip select, output enable and write enable, and its own address and write-data bus. Once the write bank holds a full frame, the block raises a ready flag and ignores any further words. The two banks exchange roles only on a frame synchronization pulse that arrives while the flag is set. A pulse that comes early is ignored, so the scanner never reads a partly written frame.

Top module: `pp_frame_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all six bank strobes are high (inactive), wrBankSel is 0 (bank 0 writes, bank 1 is read), frameReady is 0 and rdDataValid is 0.
- R2: A cycle with wrValid high and frameReady low drives the write bank's csN and weN low in the next cycle, with wrData on that bank's write-data bus. The read bank's weN stays high.
- R3: Write addresses start at 0 and increase by one for each accepted word only. Idle cycles do not advance the address.
- R4: A cycle with rdReq high drives the read bank's csN and oeN low in the next cycle, with that bank's address equal to rdAddr. The write bank's oeN stays high. Read addresses may come in any order.
- R5: The read bank's returned data appears on rdData, with rdDataValid high, two cycles after the request cycle.
- R6: frameReady rises in the cycle after the FRAME_WORDS-th accepted word. While it is high, wrValid produces no write strobe on either bank.
- R7: A frameSync pulse while frameReady is high inverts wrBankSel in the next cycle and clears frameReady. The next accepted word goes to address 0 of the new write bank.
- R8: A frameSync pulse while frameReady is low leaves wrBankSel unchanged. The write address keeps counting from where it stopped.
- R9: No bank ever has oeN and weN low together, and either of them low implies that bank's csN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | DATA_W | Incoming pixel word |
| wrValid | input | 1 | wrData is valid this cycle |
| frameSync | input | 1 | Frame synchronization pulse |
| rdReq | input | 1 | Scan read request |
| rdAddr | input | ADDR_W | Scan read address |
| rdData | output | DATA_W | Word returned from the read bank |
| rdDataValid | output | 1 | rdData holds a returned word |
| wrBankSel | output | 1 | Bank currently in the write role |
| frameReady | output | 1 | Write bank holds a complete frame |
| b0CsN | output | 1 | Bank 0 chip select, active low |
| b0OeN | output | 1 | Bank 0 output enable, active low |
| b0WeN | output | 1 | Bank 0 write enable, active low |
| b0Addr | output | ADDR_W | Bank 0 address |
| b0Wdata | output | DATA_W | Bank 0 write data |
| b0Rdata | input | DATA_W | Bank 0 read data |
| b1CsN | output | 1 | Bank 1 chip select, active low |
| b1OeN | output | 1 | Bank 1 output enable, active low |
| b1WeN | output | 1 | Bank 1 write enable, active low |
| b1Addr | output | ADDR_W | Bank 1 address |
| b1Wdata | output | DATA_W | Bank 1 write data |
| b1Rdata | input | DATA_W | Bank 1 read data |

## Verification
The assertions assume frameSync, wrValid and rdReq are synchronous to clk. They also assume each bank returns read data in the same cycle that its csN and oeN are low. The role checks do not depend on which words arrive, only on the strobes and the bank select. The bench models each bank as a small array with a combinational read path and drives every input on the falling edge. The write frame is deliberately broken by an idle cycle and by an early sync, so the counting and the swap suppression are exercised against known addresses. The scan reads the finished frame in a scrambled order.

// File: rtl/pp_fbuf_pkg.sv
package pp_fbuf_pkg;
  // Per-cycle commands from the control unit to the bank datapath
  typedef struct packed {
    logic wrStb;  // write the current word into the write bank
    logic rdStb;  // read rdAddr from the read bank
    logic wrSel;  // bank index holding the write role
  } fbufStrobes_t;
endpackage

// File: rtl/fbuf_ctrl.sv
module fbuf_ctrl
  import pp_fbuf_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int FRAME_WORDS = 131072
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              rdReq,
  input  logic              frameSync,
  output fbufStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrBankSel,
  output logic              frameReady
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_WORDS - 1);

  logic wrBank, readyQ, doSwap, accept;
  logic [ADDR_W-1:0] wrCount;

  assign accept = wrValid && !readyQ;
  assign doSwap = frameSync && readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBank  <= 1'b0;
      readyQ  <= 1'b0;
      wrCount <= '0;
    end else if (doSwap) begin
      wrBank  <= ~wrBank;
      readyQ  <= 1'b0;
      wrCount <= '0;
    end else if (accept) begin
      if (wrCount == LAST_ADDR) begin
        readyQ <= 1'b1;
      end else begin
        wrCount <= wrCount + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.wrStb = accept;
    strobes.rdStb = rdReq;
    strobes.wrSel = wrBank;
  end

  assign wrAddr     = wrCount;
  assign wrBankSel  = wrBank;
  assign frameReady = readyQ;
endmodule

// File: rtl/fbuf_datapath.sv
module fbuf_datapath
  import pp_fbuf_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fbufStrobes_t                 strobes,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [ADDR_W-1:0]            rdAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [1:0][DATA_W-1:0]       bankRdata,
  output logic [1:0]                   bankCsN,
  output logic [1:0]                   bankOeN,
  output logic [1:0]                   bankWeN,
  output logic [1:0][ADDR_W-1:0]       bankAddr,
  output logic [1:0][DATA_W-1:0]       bankWdata,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdDataValid
);
  localparam int NUM_BANKS = 2;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic isWr, wrHit, rdHit;
    assign isWr  = (strobes.wrSel == 1'(b));
    assign wrHit = strobes.wrStb && isWr;
    assign rdHit = strobes.rdStb && !isWr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankCsN[b]   <= 1'b1;
        bankOeN[b]   <= 1'b1;
        bankWeN[b]   <= 1'b1;
        bankAddr[b]  <= '0;
        bankWdata[b] <= '0;
      end else begin
        bankCsN[b]   <= !(wrHit || rdHit);
        bankOeN[b]   <= !rdHit;
        bankWeN[b]   <= !wrHit;
        bankAddr[b]  <= isWr ? wrAddr : rdAddr;
        bankWdata[b] <= wrData;
      end
    end
  end

  // Read return: strobe goes out one cycle after request, data captured next
  logic rdPend, rdPendBank;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend      <= 1'b0;
      rdPendBank  <= 1'b0;
      rdData      <= '0;
      rdDataValid <= 1'b0;
    end else begin
      rdPend      <= strobes.rdStb;
      rdPendBank  <= ~strobes.wrSel;
      rdDataValid <= rdPend;
      if (rdPend) rdData <= bankRdata[rdPendBank];
    end
  end
endmodule

// File: rtl/pp_frame_buffer.sv
module pp_frame_buffer
  import pp_fbuf_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 24,
  parameter int FRAME_WORDS = 131072
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  logic              frameSync,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataValid,
  output logic              wrBankSel,
  output logic              frameReady,
  output logic              b0CsN,
  output logic              b0OeN,
  output logic              b0WeN,
  output logic [ADDR_W-1:0] b0Addr,
  output logic [DATA_W-1:0] b0Wdata,
  input  logic [DATA_W-1:0] b0Rdata,
  output logic              b1CsN,
  output logic              b1OeN,
  output logic              b1WeN,
  output logic [ADDR_W-1:0] b1Addr,
  output logic [DATA_W-1:0] b1Wdata,
  input  logic [DATA_W-1:0] b1Rdata
);
  fbufStrobes_t             strobes;
  logic [ADDR_W-1:0]        wrAddr;
  logic [1:0]               csN, oeN, weN;
  logic [1:0][ADDR_W-1:0]   addr;
  logic [1:0][DATA_W-1:0]   wdata, rdataBus;

  fbuf_ctrl #(.ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdReq(rdReq),
    .frameSync(frameSync), .strobes(strobes), .wrAddr(wrAddr),
    .wrBankSel(wrBankSel), .frameReady(frameReady)
  );

  assign rdataBus[0] = b0Rdata;
  assign rdataBus[1] = b1Rdata;

  fbuf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .bankRdata(rdataBus),
    .bankCsN(csN), .bankOeN(oeN), .bankWeN(weN), .bankAddr(addr),
    .bankWdata(wdata), .rdData(rdData), .rdDataValid(rdDataValid)
  );

  assign b0CsN = csN[0];  assign b1CsN = csN[1];
  assign b0OeN = oeN[0];  assign b1OeN = oeN[1];
  assign b0WeN = weN[0];  assign b1WeN = weN[1];
  assign b0Addr = addr[0];  assign b1Addr = addr[1];
  assign b0Wdata = wdata[0]; assign b1Wdata = wdata[1];
endmodule

// File: rtl/fbuf_checker.sv
module fbuf_checker (
  input logic clk,
  input logic rstN,
  input logic frameSync,
  input logic frameReady,
  input logic wrBankSel,
  input logic b0CsN,
  input logic b0OeN,
  input logic b0WeN,
  input logic b1CsN,
  input logic b1OeN,
  input logic b1WeN
);
  // R9
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!b0OeN && !b0WeN) && !(!b1OeN && !b1WeN));
  // R9
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!b0OeN || !b0WeN) -> !b0CsN) && ((!b1OeN || !b1WeN) -> !b1CsN));
  // R2
  we_role_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!b0WeN |-> $past(wrBankSel) == 1'b0) and (!b1WeN |-> $past(wrBankSel) == 1'b1));
  // R4
  oe_role_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!b0OeN |-> $past(wrBankSel) == 1'b1) and (!b1OeN |-> $past(wrBankSel) == 1'b0));
  // R6
  full_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |=> (b0WeN && b1WeN));
  // R7
  swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && frameReady) |=> (wrBankSel != $past(wrBankSel)) && !frameReady);
  // R8
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !frameReady) |=> $stable(wrBankSel));
endmodule

bind pp_frame_buffer fbuf_checker i_fbuf_checker (.*);

// File: tb/test_pp_frame_buffer.sv
module test_pp_frame_buffer;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int FW = 6;

  // Scan order table: {read address, expected word}
  localparam logic [11:0] SCAN_TAB [6] = '{
    {4'd5, 8'hA5}, {4'd0, 8'hA0}, {4'd3, 8'hA3},
    {4'd1, 8'hA1}, {4'd4, 8'hA4}, {4'd2, 8'hA2}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic wrValid = 1'b0, frameSync = 1'b0, rdReq = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData, b0Wdata, b1Wdata, b0Rdata, b1Rdata;
  logic rdDataValid, wrBankSel, frameReady;
  logic b0CsN, b0OeN, b0WeN, b1CsN, b1OeN, b1WeN;
  logic [AW-1:0] b0Addr, b1Addr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pp_frame_buffer #(.ADDR_W(AW), .DATA_W(DW), .FRAME_WORDS(FW)) i_pp_frame_buffer (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrValid(wrValid),
    .frameSync(frameSync), .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData),
    .rdDataValid(rdDataValid), .wrBankSel(wrBankSel), .frameReady(frameReady),
    .b0CsN(b0CsN), .b0OeN(b0OeN), .b0WeN(b0WeN), .b0Addr(b0Addr),
    .b0Wdata(b0Wdata), .b0Rdata(b0Rdata), .b1CsN(b1CsN), .b1OeN(b1OeN),
    .b1WeN(b1WeN), .b1Addr(b1Addr), .b1Wdata(b1Wdata), .b1Rdata(b1Rdata)
  );

  // Behavioural SRAM banks
  logic [DW-1:0] mem0 [16];
  logic [DW-1:0] mem1 [16];
  always_ff @(posedge clk) begin
    if (!b0CsN && !b0WeN) mem0[b0Addr] <= b0Wdata;
    if (!b1CsN && !b1WeN) mem1[b1Addr] <= b1Wdata;
  end
  assign b0Rdata = (!b0CsN && !b0OeN) ? mem0[b0Addr] : '0;
  assign b1Rdata = (!b1CsN && !b1OeN) ? mem1[b1Addr] : '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 strobes", {b0CsN, b0OeN, b0WeN, b1CsN, b1OeN, b1WeN}, 6'b111111);
    chk("R1 bank", wrBankSel, 0);
    chk("R1 ready", frameReady, 0);
    chk("R1 rdv", rdDataValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle strobes", {b0CsN, b0OeN, b0WeN, b1CsN, b1OeN, b1WeN}, 6'b111111);

    // Frame 0 into bank 0, with an idle gap
    for (int i = 0; i < FW; i++) begin
      if (i == 3) begin
        wrValid = 1'b0;
        @(negedge clk);
        chk("R3 idle no write", b0WeN, 1);
      end
      wrValid = 1'b1;
      wrData  = 8'hA0 + 8'(i);
      @(negedge clk);
      chk("R2 we write bank", {b0CsN, b0WeN}, 2'b00);
      chk("R3 write addr", b0Addr, i);
      chk("R2 write data", b0Wdata, 8'hA0 + 8'(i));
      chk("R2 read bank no we", b1WeN, 1);
    end
    chk("R6 ready after frame", frameReady, 1);
    wrData = 8'hEE;
    @(negedge clk);
    wrValid = 1'b0;
    chk("R6 full ignores write", {b0WeN, b1WeN}, 2'b11);

    // Read role on bank 1 before swap
    rdReq = 1'b1; rdAddr = 4'd2;
    @(negedge clk);
    rdReq = 1'b0;
    chk("R4 oe read bank", {b1CsN, b1OeN}, 2'b00);
    chk("R4 read addr", b1Addr, 2);
    chk("R4 write bank no oe", b0OeN, 1);

    // Swap
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    chk("R7 swap bank", wrBankSel, 1);
    chk("R7 ready cleared", frameReady, 0);

    // Scan-order reads from bank 0
    foreach (SCAN_TAB[k]) begin
      rdReq = 1'b1; rdAddr = SCAN_TAB[k][11:8];
      @(negedge clk);
      rdReq = 1'b0;
      chk("R4 scan oe", {b0CsN, b0OeN, b1OeN}, 3'b001);
      chk("R4 scan addr", b0Addr, SCAN_TAB[k][11:8]);
      @(negedge clk);
      chk("R5 rd valid", rdDataValid, 1);
      chk("R5 rd data", rdData, SCAN_TAB[k][7:0]);
    end

    // Frame 1 into bank 1, interrupted by an early sync
    for (int i = 0; i < 3; i++) begin
      wrValid = 1'b1; wrData = 8'hB0 + 8'(i);
      @(negedge clk);
      chk("R7 new bank addr", b1Addr, i);
      chk("R2 new bank we", {b1WeN, b0WeN}, 2'b01);
    end
    wrValid = 1'b0; frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    chk("R8 early sync no swap", wrBankSel, 1);
    for (int i = 3; i < FW; i++) begin
      wrValid = 1'b1; wrData = 8'hB0 + 8'(i);
      @(negedge clk);
      chk("R8 addr continues", b1Addr, i);
    end
    wrValid = 1'b0;
    chk("R6 ready frame1", frameReady, 1);
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    chk("R7 swap back", wrBankSel, 0);

    rdReq = 1'b1; rdAddr = 4'd4;
    @(negedge clk);
    rdReq = 1'b0;
    chk("R4 oe bank1", {b1OeN, b0OeN}, 2'b01);
    @(negedge clk);
    chk("R5 bank1 data", rdData, 8'hB4);
    @(negedge clk);
    chk("R5 valid drops", rdDataValid, 0);

    finish_run();
  end
endmodule